// File: doc/BRIEF.md
# Interrupt Channel Mapper and Prioritizer

This block gathers level-sensitive interrupt requests from a wide layer of peripheral expansion lines and folds them onto a narrower set of central request channels. A programmable routing field on each expansion line picks the central channel it drives. When several lines name the same central channel, they share it, and that channel is the OR of all of them. Each central channel then passes through its own enable bit. A class bit sends it either to the fast request class or to the normal request class.

The two classes are prioritized separately by fixed channel index, with the lowest index winning. For each class the block drives a registered request flag and the index of the winning channel. A plain register port, written in one cycle and read combinationally, sets up the routing fields, the enable bits and the class bits. It also exposes a read-only view of the central channels before masking. A request that is asserted before clock edge k is captured at edge k and appears on the outputs after edge k+1. The block has no streaming data path, so every pin is a plain control or status signal with no handshake.

Register layout with the default parameters. Words 0 to 11 hold the routing fields, four per word. Expansion line s uses word s/4, and its 5-bit field starts at bit 8*(s%4). Word 12 holds the enable bits, where bit c set enables central channel c. Word 13 holds the class bits, where bit c set makes channel c a fast request and clear makes it a normal request. Word 14 is the read-only pending view. Word 15 is unused.

Top module: `irq_route_prio`

## Requirements
- R1: After reset, both request outputs are 0 and both index outputs are all ones (31).
- R2: After reset, expansion lines 0 to 31 route to the central channel of the same index and lines 32 to 47 route to channel 31. All enable bits and all class bits read as 0.
- R3: A write to routing word w sets the 5-bit fields of lines 4w to 4w+3, found at bits [8f+4:8f] for f = 0 to 3. Reading the word returns these fields, with the other bits at 0.
- R4: A central channel is active when any expansion line routed to it is high, so lines that share a channel raise it together.
- R5: A central channel whose enable bit is 0 never raises either request output, even while its sources are high.
- R6: An enabled active channel with class bit 1 is reported only on the fast outputs. With class bit 0 it is reported only on the normal outputs.
- R7: Within each class the reported index is the lowest-numbered enabled active channel of that class. The two classes are resolved independently.
- R8: A class with no qualifying channel drives its request output to 0 and its index to all ones. Channel 31 pending is reported as index 31 with the request high.
- R9: A change on the expansion inputs reaches the outputs two clock edges later. After one edge the outputs still show the previous result.
- R10: Reading word 14 returns the active state of every central channel after one input register stage, without masking and regardless of class.
- R11: Writes to word 14 or word 15 change no enable, class or routing state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 48 | Level-sensitive expansion requests |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Combinational read data |
| fiq_req_o | output | 1 | A fast-class channel is pending |
| fiq_idx_o | output | 5 | Winning fast-class channel, all ones if none |
| irq_req_o | output | 1 | A normal-class channel is pending |
| irq_idx_o | output | 5 | Winning normal-class channel, all ones if none |

## Verification
Assertions check several properties on every cycle:
- a reported channel was enabled and of the right class one cycle earlier;
- no lower-numbered qualifying channel was passed over;
- an idle class shows the all-ones code;
- a single channel never appears on both outputs at once;
- writes to the pending word leave the configuration untouched.

The routing itself can only be shown by the bench's scenarios: shared channels, remapped high expansion lines, field positions on readback and the exact two-edge latency. The scoreboard compares those against a model built from the register layout.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Spacing of routing fields inside a configuration word.
  localparam int FIELD_STRIDE = 8;

  function automatic int route_words(input int n_src, input int data_w);
    int per_word;
    per_word = data_w / FIELD_STRIDE;
    return (n_src + per_word - 1) / per_word;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int N_SRC  = 48,
  parameter int N_CH   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  input  logic [N_CH-1:0]             pend_i,
  output logic [N_SRC-1:0][CH_W-1:0]  route_o,
  output logic [N_CH-1:0]             mask_o,
  output logic [N_CH-1:0]             type_o
);
  localparam int FPW    = DATA_W / FIELD_STRIDE;
  localparam int RW     = route_words(N_SRC, DATA_W);
  localparam int A_MASK = RW;
  localparam int A_TYPE = RW + 1;
  localparam int A_PEND = RW + 2;

  // Routing fields: one register per expansion line.
  for (genvar s = 0; s < N_SRC; s++) begin : g_route
    localparam int RST_CH = (s < N_CH) ? s : N_CH - 1;
    localparam int WORD   = s / FPW;
    localparam int LSB    = (s % FPW) * FIELD_STRIDE;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        route_o[s] <= RST_CH[CH_W-1:0];
      else if (wr_en && wr_addr == ADDR_W'(WORD))
        route_o[s] <= wr_data[LSB +: CH_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      type_o <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_MASK)) mask_o <= wr_data[N_CH-1:0];
      if (wr_addr == ADDR_W'(A_TYPE)) type_o <= wr_data[N_CH-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(RW)) begin
      for (int f = 0; f < FPW; f++) begin
        if (int'(rd_addr) * FPW + f < N_SRC)
          rd_data[f*FIELD_STRIDE +: CH_W] = route_o[int'(rd_addr) * FPW + f];
      end
    end else if (rd_addr == ADDR_W'(A_MASK)) begin
      rd_data[N_CH-1:0] = mask_o;
    end else if (rd_addr == ADDR_W'(A_TYPE)) begin
      rd_data[N_CH-1:0] = type_o;
    end else if (rd_addr == ADDR_W'(A_PEND)) begin
      rd_data[N_CH-1:0] = pend_i;
    end
  end

  AST_PEND_WORD_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_PEND)) |=> (mask_o == $past(mask_o) && type_o == $past(type_o))); // R11
endmodule

// File: rtl/irq_route_or.sv
module irq_route_or #(
  parameter int N_SRC = 48,
  parameter int N_CH  = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_SRC-1:0]           src_i,
  input  logic [N_SRC-1:0][CH_W-1:0] route_i,
  output logic [N_CH-1:0]            central_o
);
  // Many-to-one fold: every central channel ORs the lines that name it.
  always_comb begin
    central_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (src_i[s] && route_i[s] == CH_W'(c))
          central_o[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_CH  = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] vec_i,
  output logic            found_o,
  output logic [CH_W-1:0] idx_o
);
  // Scan from the top so the lowest set bit is the last to assign.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '1;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_route_prio.sv
module irq_route_prio #(
  parameter int N_SRC  = 48,
  parameter int N_CH   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              fiq_req_o,
  output logic [CH_W-1:0]   fiq_idx_o,
  output logic              irq_req_o,
  output logic [CH_W-1:0]   irq_idx_o
);
  localparam int N_CLS = 2;  // class 0 = fast, class 1 = normal

  logic [N_SRC-1:0]           src_q;
  logic [N_SRC-1:0][CH_W-1:0] route;
  logic [N_CH-1:0]            mask, ctype, central;
  logic [N_CLS-1:0][N_CH-1:0] cand;
  logic [N_CLS-1:0]           found, req_q;
  logic [N_CLS-1:0][CH_W-1:0] idx, idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_req;
  end

  irq_cfg_regs #(.N_SRC(N_SRC), .N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pend_i(central),
    .route_o(route), .mask_o(mask), .type_o(ctype)
  );

  irq_route_or #(.N_SRC(N_SRC), .N_CH(N_CH)) u_or (
    .src_i(src_q), .route_i(route), .central_o(central)
  );

  assign cand[0] = central & mask & ctype;
  assign cand[1] = central & mask & ~ctype;

  for (genvar k = 0; k < N_CLS; k++) begin : g_cls
    irq_prio_enc #(.N_CH(N_CH)) u_enc (
      .vec_i(cand[k]), .found_o(found[k]), .idx_o(idx[k])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[k] <= 1'b0;
        idx_q[k] <= '1;
      end else begin
        req_q[k] <= found[k];
        idx_q[k] <= idx[k];
      end
    end
  end

  assign fiq_req_o = req_q[0];
  assign fiq_idx_o = idx_q[0];
  assign irq_req_o = req_q[1];
  assign irq_idx_o = idx_q[1];

  // Checker state: candidate vectors as they stood one cycle back.
  logic [N_CLS-1:0][N_CH-1:0] cand_past;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cand_past <= '0;
    else        cand_past <= cand;
  end

  AST_FIQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req_o |-> cand_past[0][fiq_idx_o]); // R5
  AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> cand_past[1][irq_idx_o]); // R6
  AST_FIQ_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req_o |-> ((cand_past[0] & ((N_CH'(1) << fiq_idx_o) - N_CH'(1))) == '0)); // R7
  AST_IRQ_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ((cand_past[1] & ((N_CH'(1) << irq_idx_o) - N_CH'(1))) == '0)); // R7
  AST_NONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!fiq_req_o |-> fiq_idx_o == '1) and (!irq_req_o |-> irq_idx_o == '1))); // R8
  AST_SINGLE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    !(fiq_req_o && irq_req_o && fiq_idx_o == irq_idx_o)); // R6
  AST_NO_SOURCE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_req_o || irq_req_o) |-> $past(|src_q)); // R9
endmodule

// File: tb/sim_irq_route_prio.sv
`timescale 1ns/1ps
module sim_irq_route_prio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] src_req = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        fiq_req_o, irq_req_o;
  logic [4:0]  fiq_idx_o, irq_idx_o;

  irq_route_prio u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .fiq_req_o(fiq_req_o), .fiq_idx_o(fiq_idx_o), .irq_req_o(irq_req_o), .irq_idx_o(irq_idx_o)
  );

  always #2 clk = ~clk;  // 250 MHz

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model built from the register layout in the requirements.
  int          route_m [48];
  logic [31:0] mask_m, type_m;
  logic [47:0] src_v = '0;

  // Scoreboard queues: due cycle, expected {fiq_req,fiq_idx,irq_req,irq_idx}, tag.
  int          due_q[$];
  logic [11:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] expect_of(input logic [47:0] s);
    logic [31:0] cen, cf, ci;
    logic fr, ir;
    logic [4:0] fi, ii;
    cen = '0;
    for (int k = 0; k < 48; k++) if (s[k]) cen[route_m[k]] = 1'b1;
    cf = cen & mask_m & type_m;
    ci = cen & mask_m & ~type_m;
    fr = 0; ir = 0; fi = 5'h1f; ii = 5'h1f;
    for (int c = 31; c >= 0; c--) begin
      if (cf[c]) begin fr = 1; fi = 5'(c); end
      if (ci[c]) begin ir = 1; ii = 5'(c); end
    end
    return {fr, fi, ir, ii};
  endfunction

  // Monitor: compare outputs when a queued item falls due.
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] == cyc) begin
      check(tag_q[0], {20'd0, fiq_req_o, fiq_idx_o, irq_req_o, irq_idx_o}, {20'd0, exp_q[0]});
      void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  // Driver: change inputs at a falling edge; one edge later old result (R9), two edges later new.
  task automatic drive(input logic [47:0] v, input string tag);
    due_q.push_back(cyc + 1); exp_q.push_back(expect_of(src_v)); tag_q.push_back({tag, " R9 hold"});
    src_req = v; src_v = v;
    due_q.push_back(cyc + 2); exp_q.push_back(expect_of(v)); tag_q.push_back(tag);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a < 12) begin
      for (int f = 0; f < 4; f++) if (a * 4 + f < 48) route_m[a*4+f] = int'(d[f*8 +: 5]);
    end else if (a == 12) mask_m = d;
    else if (a == 13) type_m = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a; #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 48; k++) route_m[k] = (k < 32) ? k : 31;
    mask_m = '0; type_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset outputs", {20'd0, fiq_req_o, fiq_idx_o, irq_req_o, irq_idx_o}, {20'd0, 12'b0_11111_0_11111});
    for (int w = 0; w < 12; w++) begin
      logic [31:0] e;
      e = '0;
      for (int f = 0; f < 4; f++) e[f*8 +: 5] = 5'((w*4+f < 32) ? w*4+f : 31);
      rd(4'(w), e, "R2 reset route");
    end
    rd(12, 32'h0, "R2 reset mask");
    rd(13, 32'h0, "R2 reset type");

    drive(48'hFFFF_FFFF_FFFF, "R5 all masked");
    rd(14, 32'hFFFF_FFFF, "R10 pending unmasked");
    drive(48'h0, "R8 idle");

    wr(12, 32'hFFFF_FFFF);
    drive(48'h20, "R6 normal ch5");
    wr(13, 32'h20);
    drive(48'h20, "R6 fast ch5");
    wr(13, (32'h1 << 7) | (32'h1 << 20));
    drive((48'h1 << 3) | (48'h1 << 7) | (48'h1 << 20), "R7 split classes");
    wr(12, ~(32'h1 << 3));
    drive((48'h1 << 3) | (48'h1 << 7) | (48'h1 << 20), "R5 mask ch3");
    wr(12, 32'hFFFF_FFFF);
    wr(13, 32'h0);

    wr(10, 32'h1F1F_1F02);
    wr(2, 32'h0B0A_0208);
    rd(10, 32'h1F1F_1F02, "R3 readback w10");
    rd(2, 32'h0B0A_0208, "R3 readback w2");
    drive(48'h1 << 40, "R4 remapped line");
    drive((48'h1 << 40) | (48'h1 << 9), "R4 shared ch2");
    rd(14, 32'h4, "R4 pending shared");
    drive(48'h1 << 32, "R8 ch31 reported");
    wr(13, 32'h8000_0000);
    drive(48'h1 << 32, "R6 fast ch31");

    wr(14, 32'h0);
    wr(15, 32'h0);
    rd(12, 32'hFFFF_FFFF, "R11 mask kept");
    rd(13, 32'h8000_0000, "R11 type kept");
    rd(10, 32'h1F1F_1F02, "R11 route kept");
    drive(48'h1 << 32, "R11 output kept");
    drive(48'h0, "R8 none pending");

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule